// File: doc/BRIEF.md
# System Call Entry State Unit

This block computes the architectural state change that a fast system-call instruction makes in a 64-bit processor. The pipeline gives it a one-cycle request together with a snapshot of the caller's state. That snapshot is the instruction pointer, the instruction length and the flags. It also carries the mode bits, the lock-prefix indication, the configuration registers that hold the entry target, the selector base and the flag mask, and the shadow-stack pointer with its enable bits. One cycle later the block returns a done pulse carrying one of three outcomes.

The first outcome is an invalid-opcode fault. The second is a request for the alternate event-delivery path. The third is the complete entry state. That state holds:
- the new instruction pointer and the saved return address;
- the saved and masked flags;
- the kernel code and stack selectors with their hard-wired descriptor cache contents;
- privilege level zero;
- the shadow-stack and branch-tracking state.

The block never touches the stack pointer. It has no memory access and no descriptor-table lookup. The mode checks are ordered. The 64-bit mode check comes first. The choice between the alternate and the legacy path comes next. The legacy-only enable and lock checks come last.

Top module: `sys_entry_unit`

## Requirements
- R1: Every cycle with `reqValid` high is followed in the next cycle by exactly one cycle of `done` high. `done`, `faultUd` and `altReq` are low in every other cycle.
- R2: If `longActive` is 0 or `csLongBit` is 0, the result is `faultUd`=1 and `altReq`=0, whatever the other inputs are.
- R3: If the mode check passes and `altDelivery` is 1, the result is `altReq`=1 and `faultUd`=0, even when `lockPrefix` or `sysEnable` would fault. In that case `altEventType`=7, `altVector`=1 and `altLen` equals the request's `instLen`.
- R4: On the legacy path (`altDelivery`=0), `sysEnable`=0 or `lockPrefix`=1 gives `faultUd`=1.
- R5: A successful legacy entry sets `newIp` to `targetReg` and `retAddr` to `curIp + instLen`, which is the address of the next instruction.
- R6: A successful entry sets `savedFlags` to `curFlags` and `newFlags` to `curFlags & ~flagMask`.
- R7: A successful entry sets `csSel` to `selField & 16'hFFFC` (RPL forced to 0) and `ssSel` to `selField + 8`, taken modulo 2^16.
- R8: A successful entry sets both descriptor caches to base 0 and limit 20'hFFFFF. The attribute word has type in bits [3:0], S in [4], DPL in [6:5], P in [7], L in [8], D/B in [9] and G in [10]. With that layout the code attribute is 11'h59B and the stack attribute is 11'h693.
- R9: If `shadowEnCaller` is 1, a successful entry writes `pl3SspSave` with `shadowPtr` sign-adjusted: bits 63 down to ADDR_W-1 all copy bit ADDR_W-1. Otherwise `pl3SspSave` keeps its value.
- R10: A successful entry sets `cplOut` to 0. It sets `sspOut` to 0 when `shadowEnKernel` is 1 and to `shadowPtr` otherwise. When `branchTrackEn` is 1 it sets `trackerWait`=1 and `trackerSuppress`=0. Otherwise those two outputs take `curTrackerWait` and `curSuppress`.
- R11: A fault or an alternate-delivery request leaves every architectural output (R5 to R10) at its previous value. Reset sets all of them to 0, except `cplOut`, which resets to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | One-cycle request strobe |
| curIp | input | 64 | Instruction pointer of the system-call instruction |
| instLen | input | 4 | Instruction length in bytes |
| curFlags | input | 64 | Caller flags |
| longActive | input | 1 | Long mode active |
| csLongBit | input | 1 | Long bit of the current code segment |
| sysEnable | input | 1 | System-call enable bit |
| altDelivery | input | 1 | Alternate event delivery enabled |
| lockPrefix | input | 1 | Lock prefix present |
| targetReg | input | 64 | Entry target register |
| selField | input | 16 | Selector base field of the selector configuration register |
| flagMask | input | 64 | Flag mask register |
| shadowPtr | input | 64 | Current shadow-stack pointer |
| shadowEnCaller | input | 1 | Shadow stacks enabled at caller level |
| shadowEnKernel | input | 1 | Shadow stacks enabled at level 0 |
| branchTrackEn | input | 1 | Indirect-branch tracking enabled at level 0 |
| curTrackerWait | input | 1 | Current tracker wait state |
| curSuppress | input | 1 | Current tracker suppress bit |
| done | output | 1 | Result valid, one cycle |
| faultUd | output | 1 | Invalid-opcode fault |
| altReq | output | 1 | Alternate event-delivery request |
| altEventType | output | 4 | Event type of the delivery request |
| altVector | output | 8 | Vector of the delivery request |
| altLen | output | 4 | Instruction length carried by the request |
| newIp | output | 64 | Instruction pointer after entry |
| retAddr | output | 64 | Saved return address |
| savedFlags | output | 64 | Saved caller flags |
| newFlags | output | 64 | Masked flags |
| csSel | output | 16 | Kernel code selector |
| ssSel | output | 16 | Kernel stack selector |
| csBase | output | 32 | Code cache base |
| csLimit | output | 20 | Code cache limit |
| csAttr | output | 11 | Code cache attributes |
| ssBase | output | 32 | Stack cache base |
| ssLimit | output | 20 | Stack cache limit |
| ssAttr | output | 11 | Stack cache attributes |
| cplOut | output | 2 | Current privilege level |
| pl3SspSave | output | 64 | Saved user shadow-stack pointer |
| sspOut | output | 64 | Shadow-stack pointer after entry |
| trackerWait | output | 1 | Tracker waiting for an end-branch |
| trackerSuppress | output | 1 | Tracker suppress bit |

## Verification
Some behaviours are checked by the assertions on every cycle:
- the one-cycle done pulse after each request;
- the fault when the 64-bit mode check fails;
- the event type and vector of an alternate-delivery request;
- the return address and the flag masking;
- the zero RPL and privilege level after entry;
- the held state after a fault.

Other behaviours only the bench scenarios can show. These are the full ordering of the legacy checks against the alternate path, the sign adjustment of the saved shadow pointer at the address-width boundary, and the stack selector wrapping at 16'hFFFF. The bench also confirms that state stays unchanged across long runs of mixed faults and successes.

// File: rtl/sys_entry_pkg.sv
`timescale 1ns/1ps
package sys_entry_pkg;
  localparam int XLEN = 64;
  localparam int SEL_W = 16;
  localparam int ATTR_W = 11;
  localparam int BASE_W = 32;
  localparam int LIMIT_W = 20;

  localparam logic [3:0] ALT_EVENT_TYPE = 4'd7;
  localparam logic [7:0] ALT_VECTOR = 8'd1;
  localparam logic [SEL_W-1:0] RPL_CLEAR_MASK = 16'hFFFC;
  localparam logic [SEL_W-1:0] STACK_SEL_OFFSET = 16'd8;
  localparam logic [LIMIT_W-1:0] FLAT_LIMIT = 20'hFFFFF;
  localparam logic [BASE_W-1:0] FLAT_BASE = '0;

  typedef struct packed {
    logic gran;
    logic defSize;
    logic longSeg;
    logic present;
    logic [1:0] dpl;
    logic sysFlag;
    logic [3:0] segType;
  } segAttr_t;

  localparam segAttr_t CODE_ATTR = '{gran: 1'b1, defSize: 1'b0, longSeg: 1'b1,
                                     present: 1'b1, dpl: 2'd0, sysFlag: 1'b1,
                                     segType: 4'd11};
  localparam segAttr_t STACK_ATTR = '{gran: 1'b1, defSize: 1'b1, longSeg: 1'b0,
                                      present: 1'b1, dpl: 2'd0, sysFlag: 1'b1,
                                      segType: 4'd3};

  typedef struct packed {
    logic finish;
    logic raiseUd;
    logic raiseAlt;
    logic commitArch;
    logic saveShadow;
    logic zeroShadow;
    logic armTracker;
  } entryStrobes_t;
endpackage

// File: rtl/sys_entry_ctrl.sv
`timescale 1ns/1ps
module sys_entry_ctrl
  import sys_entry_pkg::*;
(
  input  logic reqValid,
  input  logic longActive,
  input  logic csLongBit,
  input  logic sysEnable,
  input  logic altDelivery,
  input  logic lockPrefix,
  input  logic shadowEnCaller,
  input  logic shadowEnKernel,
  input  logic branchTrackEn,
  output entryStrobes_t strobes
);
  logic modeBad;
  logic legacyBad;
  logic goAlt;
  logic goLegacy;

  // Ordered checks: 64-bit mode first, then path choice, then legacy-only checks.
  always_comb begin
    modeBad   = !longActive || !csLongBit;
    goAlt     = !modeBad && altDelivery;
    legacyBad = !sysEnable || lockPrefix;
    goLegacy  = !modeBad && !altDelivery && !legacyBad;

    strobes            = '0;
    strobes.finish     = reqValid;
    strobes.raiseUd    = reqValid && (modeBad || (!altDelivery && legacyBad));
    strobes.raiseAlt   = reqValid && goAlt;
    strobes.commitArch = reqValid && goLegacy;
    strobes.saveShadow = reqValid && goLegacy && shadowEnCaller;
    strobes.zeroShadow = reqValid && goLegacy && shadowEnKernel;
    strobes.armTracker = reqValid && goLegacy && branchTrackEn;
  end
endmodule

// File: rtl/sys_entry_dp.sv
`timescale 1ns/1ps
module sys_entry_dp
  import sys_entry_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic clk,
  input  logic rstN,
  input  entryStrobes_t strobes,
  input  logic [XLEN-1:0] curIp,
  input  logic [3:0] instLen,
  input  logic [XLEN-1:0] curFlags,
  input  logic [XLEN-1:0] targetReg,
  input  logic [SEL_W-1:0] selField,
  input  logic [XLEN-1:0] flagMask,
  input  logic [XLEN-1:0] shadowPtr,
  input  logic curTrackerWait,
  input  logic curSuppress,
  output logic done,
  output logic faultUd,
  output logic altReq,
  output logic [3:0] altEventType,
  output logic [7:0] altVector,
  output logic [3:0] altLen,
  output logic [XLEN-1:0] newIp,
  output logic [XLEN-1:0] retAddr,
  output logic [XLEN-1:0] savedFlags,
  output logic [XLEN-1:0] newFlags,
  output logic [SEL_W-1:0] csSel,
  output logic [SEL_W-1:0] ssSel,
  output logic [BASE_W-1:0] csBase,
  output logic [LIMIT_W-1:0] csLimit,
  output logic [ATTR_W-1:0] csAttr,
  output logic [BASE_W-1:0] ssBase,
  output logic [LIMIT_W-1:0] ssLimit,
  output logic [ATTR_W-1:0] ssAttr,
  output logic [1:0] cplOut,
  output logic [XLEN-1:0] pl3SspSave,
  output logic [XLEN-1:0] sspOut,
  output logic trackerWait,
  output logic trackerSuppress
);
  localparam int SIGN_BIT = ADDR_W - 1;
  localparam logic [1:0] RESET_CPL = 2'd3;

  logic [XLEN-1:0] adjustedSsp;
  logic [XLEN-1:0] nextRet;
  logic [XLEN-1:0] nextFlags;
  logic [SEL_W-1:0] nextCsSel;
  logic [SEL_W-1:0] nextSsSel;

  // Sign adjustment: bits at or above the address width copy the top address bit.
  for (genvar bitIdx = 0; bitIdx < XLEN; bitIdx++) begin : g_adjust
    if (bitIdx < SIGN_BIT) begin : g_keep
      assign adjustedSsp[bitIdx] = shadowPtr[bitIdx];
    end else begin : g_extend
      assign adjustedSsp[bitIdx] = shadowPtr[SIGN_BIT];
    end
  end

  always_comb begin
    nextRet   = curIp + {{(XLEN-4){1'b0}}, instLen};
    nextFlags = curFlags & ~flagMask;
    nextCsSel = selField & RPL_CLEAR_MASK;
    nextSsSel = selField + STACK_SEL_OFFSET;
  end

  // Result pulse and delivery request fields.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      done         <= 1'b0;
      faultUd      <= 1'b0;
      altReq       <= 1'b0;
      altEventType <= '0;
      altVector    <= '0;
      altLen       <= '0;
    end else begin
      done    <= strobes.finish;
      faultUd <= strobes.raiseUd;
      altReq  <= strobes.raiseAlt;
      if (strobes.raiseAlt) begin
        altEventType <= ALT_EVENT_TYPE;
        altVector    <= ALT_VECTOR;
        altLen       <= instLen;
      end else begin
        altEventType <= '0;
        altVector    <= '0;
        altLen       <= '0;
      end
    end
  end

  // Architectural state loaded only on a committed legacy entry.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      newIp      <= '0;
      retAddr    <= '0;
      savedFlags <= '0;
      newFlags   <= '0;
      csSel      <= '0;
      ssSel      <= '0;
      csBase     <= '0;
      csLimit    <= '0;
      csAttr     <= '0;
      ssBase     <= '0;
      ssLimit    <= '0;
      ssAttr     <= '0;
      cplOut     <= RESET_CPL;
    end else if (strobes.commitArch) begin
      newIp      <= targetReg;
      retAddr    <= nextRet;
      savedFlags <= curFlags;
      newFlags   <= nextFlags;
      csSel      <= nextCsSel;
      ssSel      <= nextSsSel;
      csBase     <= FLAT_BASE;
      csLimit    <= FLAT_LIMIT;
      csAttr     <= CODE_ATTR;
      ssBase     <= FLAT_BASE;
      ssLimit    <= FLAT_LIMIT;
      ssAttr     <= STACK_ATTR;
      cplOut     <= 2'd0;
    end
  end

  // Shadow-stack and branch-tracking state.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pl3SspSave      <= '0;
      sspOut          <= '0;
      trackerWait     <= 1'b0;
      trackerSuppress <= 1'b0;
    end else if (strobes.commitArch) begin
      if (strobes.saveShadow) pl3SspSave <= adjustedSsp;
      sspOut <= strobes.zeroShadow ? '0 : shadowPtr;
      if (strobes.armTracker) begin
        trackerWait     <= 1'b1;
        trackerSuppress <= 1'b0;
      end else begin
        trackerWait     <= curTrackerWait;
        trackerSuppress <= curSuppress;
      end
    end
  end
endmodule

// File: rtl/sys_entry_unit.sv
`timescale 1ns/1ps
module sys_entry_unit
  import sys_entry_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic [63:0] curIp,
  input  logic [3:0] instLen,
  input  logic [63:0] curFlags,
  input  logic longActive,
  input  logic csLongBit,
  input  logic sysEnable,
  input  logic altDelivery,
  input  logic lockPrefix,
  input  logic [63:0] targetReg,
  input  logic [15:0] selField,
  input  logic [63:0] flagMask,
  input  logic [63:0] shadowPtr,
  input  logic shadowEnCaller,
  input  logic shadowEnKernel,
  input  logic branchTrackEn,
  input  logic curTrackerWait,
  input  logic curSuppress,
  output logic done,
  output logic faultUd,
  output logic altReq,
  output logic [3:0] altEventType,
  output logic [7:0] altVector,
  output logic [3:0] altLen,
  output logic [63:0] newIp,
  output logic [63:0] retAddr,
  output logic [63:0] savedFlags,
  output logic [63:0] newFlags,
  output logic [15:0] csSel,
  output logic [15:0] ssSel,
  output logic [31:0] csBase,
  output logic [19:0] csLimit,
  output logic [10:0] csAttr,
  output logic [31:0] ssBase,
  output logic [19:0] ssLimit,
  output logic [10:0] ssAttr,
  output logic [1:0] cplOut,
  output logic [63:0] pl3SspSave,
  output logic [63:0] sspOut,
  output logic trackerWait,
  output logic trackerSuppress
);
  entryStrobes_t strobes;

  sys_entry_ctrl u_ctrl (
    .reqValid       (reqValid),
    .longActive     (longActive),
    .csLongBit      (csLongBit),
    .sysEnable      (sysEnable),
    .altDelivery    (altDelivery),
    .lockPrefix     (lockPrefix),
    .shadowEnCaller (shadowEnCaller),
    .shadowEnKernel (shadowEnKernel),
    .branchTrackEn  (branchTrackEn),
    .strobes        (strobes)
  );

  sys_entry_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .strobes         (strobes),
    .curIp           (curIp),
    .instLen         (instLen),
    .curFlags        (curFlags),
    .targetReg       (targetReg),
    .selField        (selField),
    .flagMask        (flagMask),
    .shadowPtr       (shadowPtr),
    .curTrackerWait  (curTrackerWait),
    .curSuppress     (curSuppress),
    .done            (done),
    .faultUd         (faultUd),
    .altReq          (altReq),
    .altEventType    (altEventType),
    .altVector       (altVector),
    .altLen          (altLen),
    .newIp           (newIp),
    .retAddr         (retAddr),
    .savedFlags      (savedFlags),
    .newFlags        (newFlags),
    .csSel           (csSel),
    .ssSel           (ssSel),
    .csBase          (csBase),
    .csLimit         (csLimit),
    .csAttr          (csAttr),
    .ssBase          (ssBase),
    .ssLimit         (ssLimit),
    .ssAttr          (ssAttr),
    .cplOut          (cplOut),
    .pl3SspSave      (pl3SspSave),
    .sspOut          (sspOut),
    .trackerWait     (trackerWait),
    .trackerSuppress (trackerSuppress)
  );
endmodule

// File: rtl/sys_entry_chk.sv
`timescale 1ns/1ps
module sys_entry_chk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic [63:0] curIp,
  input logic [3:0] instLen,
  input logic [63:0] curFlags,
  input logic longActive,
  input logic csLongBit,
  input logic sysEnable,
  input logic altDelivery,
  input logic lockPrefix,
  input logic [63:0] flagMask,
  input logic done,
  input logic faultUd,
  input logic altReq,
  input logic [3:0] altEventType,
  input logic [7:0] altVector,
  input logic [63:0] newIp,
  input logic [63:0] retAddr,
  input logic [63:0] savedFlags,
  input logic [63:0] newFlags,
  input logic [15:0] csSel,
  input logic [1:0] cplOut
);
  logic legacyOk;
  assign legacyOk = longActive && csLongBit && !altDelivery && sysEnable && !lockPrefix;

  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> done); // R1
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !done && !faultUd && !altReq); // R1
  AST_MODE_FAULT_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && (!longActive || !csLongBit) |=> faultUd && !altReq); // R2
  AST_ALT_FIELDS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && longActive && csLongBit && altDelivery |=>
      altReq && !faultUd && altEventType == 4'd7 && altVector == 8'd1); // R3
  AST_LEGACY_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && longActive && csLongBit && !altDelivery && (!sysEnable || lockPrefix)
      |=> faultUd); // R4
  AST_RETURN_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && legacyOk |=> retAddr == $past(curIp) + {60'd0, $past(instLen)}); // R5
  AST_FLAG_MASK: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && legacyOk |=> (newFlags & $past(flagMask)) == 64'd0
      && savedFlags == $past(curFlags)); // R6
  AST_KERNEL_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    done && !faultUd && !altReq |-> csSel[1:0] == 2'b00 && cplOut == 2'd0); // R7
  AST_HOLD_ON_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    done && (faultUd || altReq) |-> $stable(newIp) && $stable(retAddr)
      && $stable(cplOut) && $stable(newFlags)); // R11
endmodule

bind sys_entry_unit sys_entry_chk u_chk (.*);

// File: tb/sys_entry_unit_bench.sv
`timescale 1ns/1ps
module sys_entry_unit_bench;
  localparam int ADDR_W = 48;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [63:0] curIp = '0, curFlags = '0, targetReg = '0, flagMask = '0, shadowPtr = '0;
  logic [3:0] instLen = '0;
  logic [15:0] selField = '0;
  logic longActive = 0, csLongBit = 0, sysEnable = 0, altDelivery = 0, lockPrefix = 0;
  logic shadowEnCaller = 0, shadowEnKernel = 0, branchTrackEn = 0;
  logic curTrackerWait = 0, curSuppress = 0;

  logic done, faultUd, altReq, trackerWait, trackerSuppress;
  logic [3:0] altEventType, altLen;
  logic [7:0] altVector;
  logic [63:0] newIp, retAddr, savedFlags, newFlags, pl3SspSave, sspOut;
  logic [15:0] csSel, ssSel;
  logic [31:0] csBase, ssBase;
  logic [19:0] csLimit, ssLimit;
  logic [10:0] csAttr, ssAttr;
  logic [1:0] cplOut;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // Expected architectural state, kept by the bench.
  logic [63:0] mIp, mRet, mSaved, mFlags, mPl3, mSsp;
  logic [15:0] mCs, mSs;
  logic [31:0] mCsBase, mSsBase;
  logic [19:0] mCsLim, mSsLim;
  logic [10:0] mCsAttr, mSsAttr;
  logic [1:0] mCpl;
  logic mWait, mSup;

  always #2 clk = ~clk;

  sys_entry_unit #(.ADDR_W(ADDR_W)) u_sys_entry_unit (.*);

  function automatic logic [63:0] signAdjust(input logic [63:0] v);
    logic [63:0] r = v;
    for (int i = ADDR_W - 1; i < 64; i++) r[i] = v[ADDR_W-1];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic resetModel();
    mIp = '0; mRet = '0; mSaved = '0; mFlags = '0; mPl3 = '0; mSsp = '0;
    mCs = '0; mSs = '0; mCsBase = '0; mSsBase = '0; mCsLim = '0; mSsLim = '0;
    mCsAttr = '0; mSsAttr = '0; mCpl = 2'd3; mWait = 0; mSup = 0;
  endtask

  task automatic compareArch(input string tag);
    check(newIp == mIp, {tag, " newIp"}, newIp, mIp);
    check(retAddr == mRet, {tag, " retAddr"}, retAddr, mRet);
    check(savedFlags == mSaved, {tag, " savedFlags"}, savedFlags, mSaved);
    check(newFlags == mFlags, {tag, " newFlags"}, newFlags, mFlags);
    check(csSel == mCs && ssSel == mSs, {tag, " selectors"}, {csSel, ssSel}, {mCs, mSs});
    check(csBase == mCsBase && csLimit == mCsLim && csAttr == mCsAttr, {tag, " cs cache"},
          {csBase, csLimit, csAttr}, {mCsBase, mCsLim, mCsAttr});
    check(ssBase == mSsBase && ssLimit == mSsLim && ssAttr == mSsAttr, {tag, " ss cache"},
          {ssBase, ssLimit, ssAttr}, {mSsBase, mSsLim, mSsAttr});
    check(pl3SspSave == mPl3, {tag, " pl3SspSave"}, pl3SspSave, mPl3);
    check(cplOut == mCpl && sspOut == mSsp, {tag, " cpl/ssp"}, sspOut, mSsp);
    check(trackerWait == mWait && trackerSuppress == mSup, {tag, " tracker"},
          {trackerWait, trackerSuppress}, {mWait, mSup});
  endtask

  // One request; inputs already set at a negedge.
  task automatic fire();
    bit modeBad, expAlt, expUd, ok;
    modeBad = !longActive || !csLongBit;
    expAlt = !modeBad && altDelivery;
    expUd = modeBad || (!altDelivery && (!sysEnable || lockPrefix));
    ok = !expAlt && !expUd;
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(done == 1'b1, "R1 done pulse", done, 1);
    if (modeBad) check(faultUd && !altReq, "R2 mode fault", {faultUd, altReq}, 2'b10);
    else if (expAlt) begin
      check(altReq && !faultUd, "R3 alt request", {faultUd, altReq}, 2'b01);
      check(altEventType == 4'd7 && altVector == 8'd1 && altLen == instLen, "R3 alt fields",
            {altEventType, altVector, altLen}, {4'd7, 8'd1, instLen});
    end else if (expUd) check(faultUd && !altReq, "R4 legacy fault", {faultUd, altReq}, 2'b10);
    else check(!faultUd && !altReq, "R5 success", {faultUd, altReq}, 0);
    if (ok) begin
      mIp = targetReg;                                  // R5
      mRet = curIp + {60'd0, instLen};                  // R5
      mSaved = curFlags; mFlags = curFlags & ~flagMask; // R6
      mCs = selField & 16'hFFFC; mSs = selField + 16'd8; // R7
      mCsBase = '0; mSsBase = '0; mCsLim = 20'hFFFFF; mSsLim = 20'hFFFFF;
      mCsAttr = 11'h59B; mSsAttr = 11'h693;             // R8
      if (shadowEnCaller) mPl3 = signAdjust(shadowPtr); // R9
      mCpl = 2'd0;                                      // R10
      mSsp = shadowEnKernel ? 64'd0 : shadowPtr;
      mWait = branchTrackEn ? 1'b1 : curTrackerWait;
      mSup = branchTrackEn ? 1'b0 : curSuppress;
      compareArch("R5-state R6 R7 R8 R9 R10");
    end else compareArch("R11 hold");
  endtask

  task automatic randomInputs();
    curIp = {$urandom, $urandom}; curFlags = {$urandom, $urandom};
    targetReg = {$urandom, $urandom}; flagMask = {$urandom, $urandom};
    shadowPtr = {$urandom, $urandom}; selField = 16'($urandom);
    instLen = 4'($urandom_range(1, 15));
    longActive = ($urandom % 8) != 0; csLongBit = ($urandom % 8) != 0;
    sysEnable = ($urandom % 6) != 0; altDelivery = ($urandom % 5) == 0;
    lockPrefix = ($urandom % 7) == 0;
    shadowEnCaller = $urandom; shadowEnKernel = $urandom; branchTrackEn = $urandom;
    curTrackerWait = $urandom; curSuppress = $urandom;
  endtask

  task automatic legalBase();
    randomInputs();
    longActive = 1; csLongBit = 1; sysEnable = 1; altDelivery = 0; lockPrefix = 0;
    instLen = 4'd2;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    resetModel();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check(done == 0 && faultUd == 0 && altReq == 0, "R1 reset outputs", done, 0);
    compareArch("R11 reset");

    // Directed: plain success with +2 length
    @(negedge clk); legalBase(); fire();
    // R2: mode fault wins over alternate path
    @(negedge clk); legalBase(); longActive = 0; altDelivery = 1; fire();
    @(negedge clk); legalBase(); csLongBit = 0; fire();
    // R3: alternate path ignores lock and enable
    @(negedge clk); legalBase(); altDelivery = 1; lockPrefix = 1; sysEnable = 0; fire();
    // R4: legacy faults
    @(negedge clk); legalBase(); sysEnable = 0; fire();
    @(negedge clk); legalBase(); lockPrefix = 1; fire();
    // R7: selector wrap; R9: sign-adjust of negative address
    @(negedge clk); legalBase(); selField = 16'hFFFF; shadowEnCaller = 1;
    shadowPtr = 64'h0000_8000_0000_1230; fire();
    // R9: caller disabled keeps save register
    @(negedge clk); legalBase(); shadowEnCaller = 0; shadowPtr = 64'hFFFF_0000_0000_0040; fire();
    // R10: tracker armed, kernel shadow enabled
    @(negedge clk); legalBase(); branchTrackEn = 1; curTrackerWait = 0; curSuppress = 1;
    shadowEnKernel = 1; fire();
    // R1: idle cycle produces no pulse
    @(negedge clk);
    check(done == 0 && faultUd == 0 && altReq == 0, "R1 idle", {done, faultUd, altReq}, 0);

    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      randomInputs();
      fire();
      if ((n % 5) == 0) begin
        @(negedge clk);
        check(done == 0, "R1 no repeat", done, 0);
      end
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=hung expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule